// File: doc/BRIEF.md
# Double-Buffered Bit-Serial Port

This block sits between a processor bus and a bit-serial device. On the device side, bits arrive and leave one at a time. On the bus side, the processor moves whole bytes through a small register window. Each direction has a separate bit-clock enable, so the receive and transmit rates can differ freely while all logic runs on one system clock.

Both directions are double-buffered, which means each has a shift register and a separate holding register. On the receive side, a finished byte moves into the holding register and the shifter starts collecting the next byte at once, so the processor has a whole byte time to read. On the transmit side, the processor can write the next byte while the current one is still shifting out. That byte starts on the device line at the same edge that ends the previous byte.

A bus access is a single cycle in which `sel` and `req` are both high. The block answers with `ack` one cycle later. On a read, `rdata` is valid in that same cycle. The interrupt output combines the receive-full and transmit-empty flags, each gated by its own enable bit.

Top module: `sport_top`

## Requirements
- R1: After reset, status reads 0x02 (transmit-empty set, all other flags clear), control reads 0x00, `tx_line` is 1 and `irq` is 0.
- R2: Receive is MSB-first. On the 8th `rx_tick`, the byte goes into the receive holding register and receive-full (status bit 0) is set. Register select 0 reads the received byte.
- R3: After a transfer, the receive shifter collects the next byte straight away. The holding register keeps the earlier byte until the new byte's 8th bit arrives.
- R4: A read of register 0 clears receive-full.
- R5: If a byte completes while receive-full is still set, overrun (status bit 2) is set and the new byte replaces the held one. A read of status (register select 2) returns the flag and then clears it.
- R6: A write to register select 1 stores the transmit byte and clears transmit-empty (status bit 1). On the next cycle the byte moves into the shifter, transmit-empty is set again and busy (status bit 3) rises. The line shows the MSB, and each `tx_tick` advances one bit. `tx_line` is 1 whenever the transmit shifter is idle.
- R7: A byte written while another is shifting loads at the same edge as that byte's 8th `tx_tick`, with no idle bit in between.
- R8: Receive and transmit run at the same time on independent ticks without affecting each other.
- R9: `irq` = (receive-full AND control bit 0) OR (transmit-empty AND control bit 1). Control is register select 3, read/write, 8 bits.
- R10: `ack` is high exactly one cycle after a cycle with `sel` and `req` both high. A request made without `sel` gets no `ack` and has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Block selected by address decode |
| req | input | 1 | Bus request strobe |
| wr | input | 1 | 1 = write, 0 = read |
| rsel | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with ack |
| ack | output | 1 | Transfer accepted |
| irq | output | 1 | Interrupt request |
| rx_tick | input | 1 | Receive bit-clock enable |
| rx_line | input | 1 | Serial input bit |
| tx_tick | input | 1 | Transmit bit-clock enable |
| tx_line | output | 1 | Serial output bit |

## Verification
The hardest case to reach is the collision at the edges of a byte. One instance is a second transmit byte waiting while the 8th `tx_tick` of the first byte arrives. Another is a received byte that completes while the previous one is still unread. The bench sets up each case on purpose. It writes the second transmit byte mid-shift and then checks that the line shows the new MSB right after the final tick. It also withholds the receive-data read across a full byte so that overrun appears, then checks that overrun clears on the status read while the latest byte stays held.

// File: rtl/sport_pkg.sv
package sport_pkg;
    typedef enum logic [1:0] {
        REG_RXD  = 2'd0,
        REG_TXD  = 2'd1,
        REG_STAT = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    localparam int STAT_RXFULL  = 0;
    localparam int STAT_TXEMPTY = 1;
    localparam int STAT_OVR     = 2;
    localparam int STAT_BUSY    = 3;
    localparam int CTRL_RXIE    = 0;
    localparam int CTRL_TXIE    = 1;
endpackage

// File: rtl/sport_rx.sv
module sport_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         din,
    input  logic         rd_data,
    input  logic         rd_stat,
    output logic [W-1:0] hold,
    output logic         full,
    output logic         ovr
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
        logic [W-1:0]  hold;
        logic          full;
        logic          ovr;
    } rx_st_t;

    rx_st_t q, d;
    logic   done;
    logic [W-1:0] next_sh;

    always_comb begin
        d       = q;
        next_sh = {q.sh[W-2:0], din};
        done    = tick && (q.cnt == LAST);
        if (tick) begin
            d.sh  = next_sh;
            d.cnt = done ? '0 : q.cnt + 1'b1;
        end
        if (rd_data) d.full = 1'b0;
        if (rd_stat) d.ovr  = 1'b0;
        if (done) begin
            d.hold = next_sh;
            d.full = 1'b1;
            if (q.full && !rd_data) d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign hold = q.hold;
    assign full = q.full;
    assign ovr  = q.ovr;

    a_r2_full_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> full);
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !done) |=> !full);
    a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full && !rd_data) |=> ovr);
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(hold));
endmodule

// File: rtl/sport_tx.sv
module sport_tx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_data,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] hold,
    output logic         empty,
    output logic         busy,
    output logic         dout
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
        logic          busy;
        logic [W-1:0]  hold;
        logic          empty;
    } tx_st_t;

    tx_st_t q, d;
    logic   last;
    logic   load;

    always_comb begin
        d    = q;
        last = q.busy && tick && (q.cnt == LAST);
        load = !q.empty && (!q.busy || last);
        if (q.busy && tick) begin
            d.sh  = {q.sh[W-2:0], 1'b0};
            d.cnt = q.cnt + 1'b1;
            if (last) begin
                d.busy = 1'b0;
                d.cnt  = '0;
            end
        end
        if (load) begin
            d.sh    = q.hold;
            d.cnt   = '0;
            d.busy  = 1'b1;
            d.empty = 1'b1;
        end
        if (wr_data) begin
            d.hold  = wdata;
            d.empty = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.empty <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign hold  = q.hold;
    assign empty = q.empty;
    assign busy  = q.busy;
    assign dout  = q.busy ? q.sh[W-1] : 1'b1;

    a_r6_load_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_data) |=> (empty && busy));
    a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> dout);
    a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !empty) |=> busy);
endmodule

// File: rtl/sport_regs.sv
module sport_regs
    import sport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         req,
    input  logic         wr,
    input  logic [1:0]   rsel,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] rx_hold,
    input  logic         rx_full,
    input  logic         rx_ovr,
    input  logic [W-1:0] tx_hold,
    input  logic         tx_empty,
    input  logic         tx_busy,
    output logic         rd_rx,
    output logic         rd_stat,
    output logic         wr_tx,
    output logic [W-1:0] rdata,
    output logic         ack,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] rdata;
        logic         ack;
        logic [W-1:0] ctrl;
    } rg_st_t;

    rg_st_t   q, d;
    logic     hit;
    reg_sel_e rs;
    logic [W-1:0] stat;
    logic [W-1:0] mux;

    always_comb begin
        hit  = sel && req;
        rs   = reg_sel_e'(rsel);
        stat = '0;
        stat[STAT_RXFULL]  = rx_full;
        stat[STAT_TXEMPTY] = tx_empty;
        stat[STAT_OVR]     = rx_ovr;
        stat[STAT_BUSY]    = tx_busy;
        case (rs)
            REG_RXD:  mux = rx_hold;
            REG_TXD:  mux = tx_hold;
            REG_STAT: mux = stat;
            default:  mux = q.ctrl;
        endcase
        rd_rx   = hit && !wr && (rs == REG_RXD);
        rd_stat = hit && !wr && (rs == REG_STAT);
        wr_tx   = hit && wr && (rs == REG_TXD);

        d       = q;
        d.ack   = hit;
        d.rdata = (hit && !wr) ? mux : '0;
        if (hit && wr && (rs == REG_CTRL)) d.ctrl = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.rdata;
    assign ack   = q.ack;
    assign irq   = (rx_full && q.ctrl[CTRL_RXIE]) || (tx_empty && q.ctrl[CTRL_TXIE]);

    a_r10_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && req) |=> ack);
    a_r10_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && req) |=> !ack);
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_full && !tx_empty) |-> !irq);
endmodule

// File: rtl/sport_top.sv
module sport_top #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         req,
    input  logic         wr,
    input  logic [1:0]   rsel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         ack,
    output logic         irq,
    input  logic         rx_tick,
    input  logic         rx_line,
    input  logic         tx_tick,
    output logic         tx_line
);
    logic [W-1:0] rx_hold, tx_hold;
    logic rx_full, rx_ovr, tx_empty, tx_busy;
    logic rd_rx, rd_stat, wr_tx;

    sport_rx #(.W(W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(rx_tick), .din(rx_line),
        .rd_data(rd_rx), .rd_stat(rd_stat),
        .hold(rx_hold), .full(rx_full), .ovr(rx_ovr)
    );

    sport_tx #(.W(W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tx_tick), .wr_data(wr_tx),
        .wdata(wdata), .hold(tx_hold), .empty(tx_empty), .busy(tx_busy),
        .dout(tx_line)
    );

    sport_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .req(req), .wr(wr),
        .rsel(rsel), .wdata(wdata),
        .rx_hold(rx_hold), .rx_full(rx_full), .rx_ovr(rx_ovr),
        .tx_hold(tx_hold), .tx_empty(tx_empty), .tx_busy(tx_busy),
        .rd_rx(rd_rx), .rd_stat(rd_stat), .wr_tx(wr_tx),
        .rdata(rdata), .ack(ack), .irq(irq)
    );
endmodule

// File: tb/tb_sport_top.sv
`timescale 1ns/1ps
module tb_sport_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 0, req = 0, wr = 0;
    logic [1:0] rsel = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic ack, irq;
    logic rx_tick = 0, rx_line = 0, tx_tick = 0;
    logic tx_line;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sport_top dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .req(req), .wr(wr),
        .rsel(rsel), .wdata(wdata), .rdata(rdata), .ack(ack), .irq(irq),
        .rx_tick(rx_tick), .rx_line(rx_line), .tx_tick(tx_tick), .tx_line(tx_line)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        sel = 1; req = 1; wr = 0; rsel = s;
        @(negedge clk);
        sel = 0; req = 0;
        check("R10 ack on read", {7'b0, ack}, 8'h01);
        d = rdata;
    endtask

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        sel = 1; req = 1; wr = 1; rsel = s; wdata = v;
        @(negedge clk);
        sel = 0; req = 0; wr = 0;
        check("R10 ack on write", {7'b0, ack}, 8'h01);
    endtask

    task automatic rx_bit(input logic b);
        @(negedge clk);
        rx_line = b; rx_tick = 1;
        @(negedge clk);
        rx_tick = 0;
    endtask

    task automatic rx_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) rx_bit(v[i]);
    endtask

    task automatic tx_pulse();
        @(negedge clk);
        tx_tick = 1;
        @(negedge clk);
        tx_tick = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx_line idle", {7'b0, tx_line}, 8'h01);
        check("R1 irq low", {7'b0, irq}, 8'h00);
        check("R1 ack low", {7'b0, ack}, 8'h00);
        bus_rd(2'd2, d); check("R1 status", d, 8'h02);
        bus_rd(2'd3, d); check("R1 control", d, 8'h00);

        // R9 control register read/write sweep
        for (int v = 0; v < 256; v += 17) begin
            bus_wr(2'd3, 8'(v)); bus_rd(2'd3, d); check("R9 control rw", d, 8'(v));
        end
        bus_wr(2'd3, 8'h00);

        // R2 R4 receive sweep over all byte values
        for (int v = 0; v < 256; v++) begin
            rx_byte(8'(v));
            bus_rd(2'd2, d); check("R2 status full", d, 8'h03);
            bus_rd(2'd0, d); check("R2 rx byte", d, 8'(v));
            bus_rd(2'd2, d); check("R4 full cleared", d, 8'h02);
        end

        // R3 double buffering
        rx_byte(8'h5A);
        for (int i = 7; i >= 1; i--) rx_bit(8'hC3 >> i);
        bus_rd(2'd0, d); check("R3 held byte during next", d, 8'h5A);
        rx_bit(1'b1);
        bus_rd(2'd2, d); check("R3 status no overrun", d, 8'h03);
        bus_rd(2'd0, d); check("R3 second byte", d, 8'hC3);

        // R5 overrun
        rx_byte(8'h11);
        rx_byte(8'h96);
        bus_rd(2'd2, d); check("R5 overrun flagged", d, 8'h07);
        bus_rd(2'd2, d); check("R5 overrun cleared", d, 8'h03);
        bus_rd(2'd0, d); check("R5 newest byte kept", d, 8'h96);

        // R6 transmit sweep over all byte values
        for (int v = 0; v < 256; v++) begin
            bus_wr(2'd1, 8'(v));
            @(negedge clk);
            bus_rd(2'd2, d); check("R6 status busy empty", d, 8'h0A);
            for (int k = 7; k >= 0; k--) begin
                check("R6 tx bit", {7'b0, tx_line}, {7'b0, v[k]});
                tx_pulse();
            end
            check("R6 idle after byte", {7'b0, tx_line}, 8'h01);
            bus_rd(2'd2, d); check("R6 status idle", d, 8'h02);
        end

        // R7 back-to-back transmit
        bus_wr(2'd1, 8'hA5);
        @(negedge clk);
        bus_wr(2'd1, 8'h3C);
        bus_rd(2'd2, d); check("R7 second waiting", d, 8'h08);
        bus_rd(2'd1, d); check("R7 tx holding readback", d, 8'h3C);
        for (int k = 7; k >= 0; k--) begin
            check("R7 first byte bit", {7'b0, tx_line}, {7'b0, 8'hA5 >> k} & 8'h01);
            tx_pulse();
        end
        check("R7 second MSB without gap", {7'b0, tx_line}, 8'h00);
        bus_rd(2'd2, d); check("R7 second loaded", d, 8'h0A);
        for (int k = 7; k >= 0; k--) begin
            check("R7 second byte bit", {7'b0, tx_line}, {7'b0, 8'h3C >> k} & 8'h01);
            tx_pulse();
        end

        // R8 simultaneous receive and transmit
        bus_wr(2'd1, 8'h69);
        @(negedge clk);
        for (int k = 7; k >= 0; k--) begin
            check("R8 tx bit while rx", {7'b0, tx_line}, {7'b0, 8'h69 >> k} & 8'h01);
            @(negedge clk);
            rx_line = 8'hD2 >> k; rx_tick = 1; tx_tick = 1;
            @(negedge clk);
            rx_tick = 0; tx_tick = 0;
            @(negedge clk);
        end
        bus_rd(2'd0, d); check("R8 rx byte while tx", d, 8'hD2);

        // R9 interrupt gating
        check("R9 irq off when disabled", {7'b0, irq}, 8'h00);
        bus_wr(2'd3, 8'h02); @(negedge clk);
        check("R9 irq tx empty", {7'b0, irq}, 8'h01);
        bus_wr(2'd3, 8'h01); @(negedge clk);
        check("R9 irq rx idle", {7'b0, irq}, 8'h00);
        rx_byte(8'h44); @(negedge clk);
        check("R9 irq rx full", {7'b0, irq}, 8'h01);
        bus_rd(2'd0, d); @(negedge clk);
        check("R9 irq cleared by read", {7'b0, irq}, 8'h00);
        bus_wr(2'd3, 8'h00);

        // R10 unselected request has no effect
        rx_byte(8'h01); rx_byte(8'h02);
        @(negedge clk);
        sel = 0; req = 1; wr = 0; rsel = 2'd2;
        @(negedge clk);
        req = 0;
        check("R10 no ack unselected", {7'b0, ack}, 8'h00);
        @(negedge clk);
        sel = 0; req = 1; wr = 0; rsel = 2'd0;
        @(negedge clk);
        req = 0;
        bus_rd(2'd2, d); check("R10 unselected reads ignored", d, 8'h07);
        bus_rd(2'd0, d); check("R10 data intact", d, 8'h02);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule